// File: doc/BRIEF.md
# Host UART Register Mailbox

This block gives a host bus the register view of a common single-byte UART while an embedded microprocessor (the MPU) sits behind it and moves the bytes. Nothing is shifted onto a line. A byte that the MPU writes becomes the host's receive byte. A byte that the host writes as a transmit byte waits for the MPU to collect it. The status flags that host software polls are driven by these accesses. Data-ready, transmit-holding-empty and the four error bits behave as host driver code expects. Interrupts run in both directions.

The host uses a 3-bit address with read and write strobes. Bit 7 of the line control byte is the divisor-latch access bit (DLAB), and it remaps addresses 0 and 1. The MPU uses a byte address and decodes only its low byte. Every access on either side completes in the cycle its strobe is high. No access is ever stalled, so neither port has back-pressure and there is no valid/ready pair. Read data is combinational from the address. A side effect of a read, such as clearing a flag, takes hold at the clock edge that ends the read cycle. Two optional down-counters can delay the data-ready flag and the transmit-empty flag, which lets the MPU pace the host the way a real line would.

Top module: `uart_mirror_bridge`

## Requirements
- R1: After reset the host line status at address 5 reads 0x60 (bit 0 data-ready, bits 4:1 errors, bit 5 transmit-empty, bit 6 the same value as bit 5). The identification byte at address 2 reads 0x01. Both interrupt outputs are low.
- R2: An MPU write at low byte 0xF0 loads the receive byte, which the host reads at address 0 when DLAB is 0. With the receive delay disabled, data-ready is set at the write edge. A host read of address 0 clears data-ready. An MPU read at 0xF0 returns the transmit byte, never the receive byte.
- R3: The MPU writes shadow error bits at 0xF1 in bits 4:1. They are copied into line status bits 4:1 at the edge where the MPU writes 0xF0. A host read of address 5 clears those bits, but an MPU write at 0xF0 in the same cycle takes priority.
- R4: The interrupt-enable byte (address 1, DLAB 0) uses bit 0 for received data and bit 1 for transmit-empty. h_irq is high when an enabled condition holds. The identification byte reads 0x04 for received data, which takes precedence, then 0x02 for transmit-empty, and 0x01 when no enabled condition holds.
- R5: A host write at address 0 with DLAB 0 stores the transmit byte, clears transmit-empty and sets bit 0 of the MPU pending byte at 0xF5. m_irq is that bit ANDed with enable bit 0 at 0xF6. An MPU read at 0xF0 clears the pending bit.
- R6: An MPU read at 0xF0 sets transmit-empty at that edge when the transmit delay is disabled. A host transmit write in the same cycle wins: transmit-empty stays 0 and the pending bit stays 1.
- R7: The receive delay load is at 0xF2, the transmit delay load at 0xF3, and the enables are bits 0 (receive) and 1 (transmit) at 0xF4. With the enable set and load N nonzero, the flag is set N cycles after the triggering edge. A new trigger restarts the count. A load of zero sets the flag at the trigger edge.
- R8: A host write at address 2 captures bits 7:6 and 3:0. The MPU reads them at 0xE9 with bit 5 showing that a write occurred since the last such read and bit 4 showing overrun. An MPU read at 0xE9 clears bits 5 and 4 unless a setting event falls in the same cycle.
- R9: A host transmit write while transmit-empty is 0 sets the overrun bit.
- R10: The line control byte is read/write at address 3. With DLAB 1, addresses 0 and 1 read and write the low and high divisor bytes and leave the transmit byte, the receive byte, data-ready and the enable byte untouched. The MPU reads the divisor at 0xF7 and 0xF8 and the line control byte at 0xFA.
- R11: Address 7 is a read/write scratch byte that the MPU reads at 0xF9. Host addresses 4 and 6 read 0 and ignore writes, and an undecoded MPU low byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host register address |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for h_addr |
| h_irq | output | 1 | Interrupt to host |
| m_addr | input | MPU_AW | MPU address; the low byte is decoded |
| m_rd | input | 1 | MPU read strobe |
| m_wr | input | 1 | MPU write strobe |
| m_wdata | input | 8 | MPU write data |
| m_rdata | output | 8 | MPU read data for m_addr |
| m_irq | output | 1 | Interrupt to MPU |

## Verification
Two pairs of accesses can land in the same cycle and must resolve one way. The first pair is a host transmit write with an MPU transmit read. The second is an MPU receive write with a host status or receive read. The bench drives both strobes of each pair in a single step, and also lines up expiring delay counters against host clears. A behavioural model applies the stated priorities, where a set of data-ready or new error bits beats a host clear and a fresh host byte beats the MPU's collection. On every clock the model's prediction of both read buses and both interrupts is compared with the ports.

// File: rtl/umb_pkg.sv
`timescale 1ns/1ps
package umb_pkg;
  localparam int BYTE_W = 8;

  // host addresses
  localparam logic [2:0] HA_DATA = 3'd0;
  localparam logic [2:0] HA_IER  = 3'd1;
  localparam logic [2:0] HA_ID   = 3'd2;
  localparam logic [2:0] HA_LCR  = 3'd3;
  localparam logic [2:0] HA_LSR  = 3'd5;
  localparam logic [2:0] HA_SCR  = 3'd7;

  // MPU low-byte offsets
  localparam logic [7:0] MA_DATA   = 8'hF0;
  localparam logic [7:0] MA_SHADOW = 8'hF1;
  localparam logic [7:0] MA_RXLD   = 8'hF2;
  localparam logic [7:0] MA_TXLD   = 8'hF3;
  localparam logic [7:0] MA_TCTL   = 8'hF4;
  localparam logic [7:0] MA_PEND   = 8'hF5;
  localparam logic [7:0] MA_MIEN   = 8'hF6;
  localparam logic [7:0] MA_DLL    = 8'hF7;
  localparam logic [7:0] MA_DLM    = 8'hF8;
  localparam logic [7:0] MA_SCR    = 8'hF9;
  localparam logic [7:0] MA_LCR    = 8'hFA;
  localparam logic [7:0] MA_FCR    = 8'hE9;

  // identification codes, received data outranks transmit-empty
  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_THRE = 8'h02;
  localparam logic [7:0] ID_RXAV = 8'h04;

  localparam int N_TMR  = 2;
  localparam int TMR_RX = 0;
  localparam int TMR_TX = 1;

  typedef struct packed {
    logic [1:0] trig;
    logic       wrote;
    logic       ovr;
    logic [3:0] ctl;
  } fcr_view_t;
endpackage

// File: rtl/umb_delay_timer.sv
`timescale 1ns/1ps
module umb_delay_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          en,
  input  logic [TW-1:0] load,
  output logic          fire
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt;
  logic          run;
  logic          armed;

  assign armed = en && (load != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (trig) begin
      run <= armed;
      cnt <= load;
    end else if (run) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) run <= 1'b0;
    end
  end

  // immediate on an unarmed trigger, otherwise on the last count
  always_comb begin
    if (trig) fire = !armed;
    else      fire = run && (cnt == ONE);
  end
endmodule

// File: rtl/umb_host_regs.sv
`timescale 1ns/1ps
module umb_host_regs
  import umb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        h_addr,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [BYTE_W-1:0] h_wdata,
  output logic [BYTE_W-1:0] h_rdata,
  output logic              irq,
  input  logic [BYTE_W-1:0] rbr_q,
  input  logic              dr,
  input  logic [3:0]        err,
  input  logic              thre,
  output logic [BYTE_W-1:0] lcr_q,
  output logic [BYTE_W-1:0] dll_q,
  output logic [BYTE_W-1:0] dlm_q,
  output logic [BYTE_W-1:0] scr_q,
  output logic [5:0]        fcr_q,
  output logic              thr_wr,
  output logic              rbr_rd,
  output logic              lsr_rd,
  output logic              fcr_wr
);
  logic [3:0]        ier_q;
  logic              dlab;
  logic [BYTE_W-1:0] id_code;

  assign dlab   = lcr_q[7];
  assign thr_wr = h_wr && (h_addr == HA_DATA) && !dlab;
  assign rbr_rd = h_rd && (h_addr == HA_DATA) && !dlab;
  assign lsr_rd = h_rd && (h_addr == HA_LSR);
  assign fcr_wr = h_wr && (h_addr == HA_ID);

  always_comb begin
    if (dr && ier_q[0])        id_code = ID_RXAV;
    else if (thre && ier_q[1]) id_code = ID_THRE;
    else                       id_code = ID_NONE;
  end
  assign irq = !id_code[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
      scr_q <= '0;
      fcr_q <= '0;
    end else if (h_wr) begin
      case (h_addr)
        HA_DATA: if (dlab) dll_q <= h_wdata;
        HA_IER: begin
          if (dlab) dlm_q <= h_wdata;
          else      ier_q <= h_wdata[3:0];
        end
        HA_ID:  fcr_q <= {h_wdata[7:6], h_wdata[3:0]};
        HA_LCR: lcr_q <= h_wdata;
        HA_SCR: scr_q <= h_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (h_addr)
      HA_DATA: h_rdata = dlab ? dll_q : rbr_q;
      HA_IER:  h_rdata = dlab ? dlm_q : {4'b0, ier_q};
      HA_ID:   h_rdata = id_code;
      HA_LCR:  h_rdata = lcr_q;
      HA_LSR:  h_rdata = {1'b0, thre, thre, err, dr};
      HA_SCR:  h_rdata = scr_q;
      default: h_rdata = '0;
    endcase
  end
endmodule

// File: rtl/umb_mpu_regs.sv
`timescale 1ns/1ps
module umb_mpu_regs
  import umb_pkg::*;
#(
  parameter int AW = 8,
  parameter int TW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     m_addr,
  input  logic              m_rd,
  input  logic              m_wr,
  input  logic [BYTE_W-1:0] m_wdata,
  output logic [BYTE_W-1:0] m_rdata,
  input  logic [BYTE_W-1:0] thr_q,
  input  fcr_view_t         fcr_view,
  input  logic              pend,
  input  logic [BYTE_W-1:0] dll_q,
  input  logic [BYTE_W-1:0] dlm_q,
  input  logic [BYTE_W-1:0] scr_q,
  input  logic [BYTE_W-1:0] lcr_q,
  output logic [3:0]        shadow_q,
  output logic [TW-1:0]     rx_ld,
  output logic [TW-1:0]     tx_ld,
  output logic              rx_en,
  output logic              tx_en,
  output logic              mien,
  output logic              rbr_wr,
  output logic              thr_rd,
  output logic              fcr_rd
);
  logic [7:0] lo;

  assign lo     = m_addr[7:0];
  assign rbr_wr = m_wr && (lo == MA_DATA);
  assign thr_rd = m_rd && (lo == MA_DATA);
  assign fcr_rd = m_rd && (lo == MA_FCR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      rx_ld    <= '0;
      tx_ld    <= '0;
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      mien     <= 1'b0;
    end else if (m_wr) begin
      case (lo)
        MA_SHADOW: shadow_q <= m_wdata[4:1];
        MA_RXLD:   rx_ld    <= m_wdata[TW-1:0];
        MA_TXLD:   tx_ld    <= m_wdata[TW-1:0];
        MA_TCTL: begin
          rx_en <= m_wdata[0];
          tx_en <= m_wdata[1];
        end
        MA_MIEN:   mien     <= m_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (lo)
      MA_DATA:   m_rdata = thr_q;
      MA_SHADOW: m_rdata = {3'b0, shadow_q, 1'b0};
      MA_RXLD:   m_rdata = BYTE_W'(rx_ld);
      MA_TXLD:   m_rdata = BYTE_W'(tx_ld);
      MA_TCTL:   m_rdata = {6'b0, tx_en, rx_en};
      MA_PEND:   m_rdata = {7'b0, pend};
      MA_MIEN:   m_rdata = {7'b0, mien};
      MA_DLL:    m_rdata = dll_q;
      MA_DLM:    m_rdata = dlm_q;
      MA_SCR:    m_rdata = scr_q;
      MA_LCR:    m_rdata = lcr_q;
      MA_FCR:    m_rdata = fcr_view;
      default:   m_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_mirror_bridge.sv
`timescale 1ns/1ps
module uart_mirror_bridge
  import umb_pkg::*;
#(
  parameter int MPU_AW = 8,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        h_addr,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  output logic              h_irq,
  input  logic [MPU_AW-1:0] m_addr,
  input  logic              m_rd,
  input  logic              m_wr,
  input  logic [7:0]        m_wdata,
  output logic [7:0]        m_rdata,
  output logic              m_irq
);
  logic [BYTE_W-1:0] rbr_q, thr_q;
  logic              dr, thre, pend, fwr, ovr;
  logic [3:0]        err_q;

  logic [BYTE_W-1:0] lcr_q, dll_q, dlm_q, scr_q;
  logic [5:0]        fcr_q;
  logic              thr_wr, rbr_rd, lsr_rd, fcr_wr;

  logic [3:0]        shadow_q;
  logic [TMR_W-1:0]  rx_ld, tx_ld;
  logic              rx_en, tx_en, mien;
  logic              rbr_wr, thr_rd, fcr_rd;

  fcr_view_t         fcr_view;

  logic [N_TMR-1:0]  t_trig, t_en, t_fire;
  logic [TMR_W-1:0]  t_load [N_TMR];

  assign fcr_view = '{trig: fcr_q[5:4], wrote: fwr, ovr: ovr, ctl: fcr_q[3:0]};

  umb_host_regs u_host (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .irq(h_irq),
    .rbr_q(rbr_q), .dr(dr), .err(err_q), .thre(thre),
    .lcr_q(lcr_q), .dll_q(dll_q), .dlm_q(dlm_q), .scr_q(scr_q), .fcr_q(fcr_q),
    .thr_wr(thr_wr), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .fcr_wr(fcr_wr)
  );

  umb_mpu_regs #(.AW(MPU_AW), .TW(TMR_W)) u_mpu (
    .clk(clk), .rst_n(rst_n),
    .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata),
    .m_rdata(m_rdata),
    .thr_q(thr_q), .fcr_view(fcr_view), .pend(pend),
    .dll_q(dll_q), .dlm_q(dlm_q), .scr_q(scr_q), .lcr_q(lcr_q),
    .shadow_q(shadow_q), .rx_ld(rx_ld), .tx_ld(tx_ld),
    .rx_en(rx_en), .tx_en(tx_en), .mien(mien),
    .rbr_wr(rbr_wr), .thr_rd(thr_rd), .fcr_rd(fcr_rd)
  );

  // one delay channel per flag path
  assign t_trig[TMR_RX] = rbr_wr;
  assign t_en[TMR_RX]   = rx_en;
  assign t_load[TMR_RX] = rx_ld;
  assign t_trig[TMR_TX] = thr_rd;
  assign t_en[TMR_TX]   = tx_en;
  assign t_load[TMR_TX] = tx_ld;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    umb_delay_timer #(.TW(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .trig(t_trig[g]), .en(t_en[g]), .load(t_load[g]),
      .fire(t_fire[g])
    );
  end

  // receive path: a set beats a host clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q <= '0;
      dr    <= 1'b0;
      err_q <= '0;
    end else begin
      if (rbr_wr) rbr_q <= m_wdata;
      if (t_fire[TMR_RX]) dr <= 1'b1;
      else if (rbr_rd)    dr <= 1'b0;
      if (rbr_wr)         err_q <= shadow_q;
      else if (lsr_rd)    err_q <= '0;
    end
  end

  // transmit path: a fresh host byte beats the MPU's collection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      thre  <= 1'b1;
      pend  <= 1'b0;
      ovr   <= 1'b0;
      fwr   <= 1'b0;
    end else begin
      if (thr_wr) thr_q <= h_wdata;
      if (thr_wr)              thre <= 1'b0;
      else if (t_fire[TMR_TX]) thre <= 1'b1;
      if (thr_wr)      pend <= 1'b1;
      else if (thr_rd) pend <= 1'b0;
      if (thr_wr && !thre) ovr <= 1'b1;
      else if (fcr_rd)     ovr <= 1'b0;
      if (fcr_wr)      fwr <= 1'b1;
      else if (fcr_rd) fwr <= 1'b0;
    end
  end

  assign m_irq = pend && mien;
endmodule

// File: rtl/umb_checker.sv
`timescale 1ns/1ps
module umb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rbr_wr,
  input logic       thr_wr,
  input logic       fcr_wr,
  input logic       rx_en,
  input logic       m_wr,
  input logic       mien,
  input logic       dr,
  input logic       thre,
  input logic       pend,
  input logic       ovr,
  input logic       fwr,
  input logic [3:0] err_q,
  input logic [3:0] shadow_q,
  input logic       m_irq
);
  // R2
  dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_wr && !rx_en) |=> dr);
  // R3
  err_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_wr |=> (err_q == $past(shadow_q)));
  // R5
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (!thre && pend));
  // R5
  mpu_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && mien && !m_wr) |=> m_irq);
  // R9
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thre) |=> ovr);
  // R8
  fcr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr |=> fwr);
endmodule

bind uart_mirror_bridge umb_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .rbr_wr(rbr_wr), .thr_wr(thr_wr), .fcr_wr(fcr_wr), .rx_en(rx_en),
  .m_wr(m_wr), .mien(mien), .dr(dr), .thre(thre), .pend(pend),
  .ovr(ovr), .fwr(fwr), .err_q(err_q), .shadow_q(shadow_q), .m_irq(m_irq)
);

// File: tb/sim_uart_mirror_bridge.sv
`timescale 1ns/1ps
module sim_uart_mirror_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] h_addr = '0;
  logic       h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;
  logic       h_irq;
  logic [7:0] m_addr = '0;
  logic       m_rd = 1'b0, m_wr = 1'b0;
  logic [7:0] m_wdata = '0;
  logic [7:0] m_rdata;
  logic       m_irq;

  always #10 clk = ~clk;

  uart_mirror_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_irq(m_irq)
  );

  int    vecs = 0, miss = 0, cycles = 0;
  bit    done = 0;
  string cur = "R1";

  // behavioural reference state
  int rbr, thr, dr, err, thre, pend, shadow, ier, lcr, dll, dlm, scr;
  int fcr, fwr, ovr, rxl, txl, ctl, mien;
  int rxc, rxa, txc, txa;

  function automatic int exp_host();
    int dl = (lcr >> 7) & 1;
    int id = 1;
    if (dr && (ier & 1)) id = 4;
    else if (thre && (ier & 2)) id = 2;
    case (h_addr)
      0: return dl ? dll : rbr;
      1: return dl ? dlm : ier;
      2: return id;
      3: return lcr;
      5: return (thre << 6) | (thre << 5) | (err << 1) | dr;
      7: return scr;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_mpu();
    case (m_addr)
      8'hF0: return thr;
      8'hF1: return shadow << 1;
      8'hF2: return rxl;
      8'hF3: return txl;
      8'hF4: return ctl;
      8'hF5: return pend;
      8'hF6: return mien;
      8'hF7: return dll;
      8'hF8: return dlm;
      8'hF9: return scr;
      8'hFA: return lcr;
      8'hE9: return (fcr & 8'hCF) | (fwr << 5) | (ovr << 4);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_hirq();
    return ((dr && (ier & 1)) || (thre && (ier & 2))) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int dl, thr_w, rbr_r, lsr_r, fcr_w, rbr_w, thr_r, fcr_r, rx_fire, tx_fire, old_thre;
    if (!rst_n) begin
      rbr = 0; thr = 0; dr = 0; err = 0; thre = 1; pend = 0; shadow = 0;
      ier = 0; lcr = 0; dll = 0; dlm = 0; scr = 0; fcr = 0; fwr = 0; ovr = 0;
      rxl = 0; txl = 0; ctl = 0; mien = 0; rxc = 0; rxa = 0; txc = 0; txa = 0;
    end else begin
      dl    = (lcr >> 7) & 1;
      thr_w = (h_wr && h_addr == 0 && !dl) ? 1 : 0;
      rbr_r = (h_rd && h_addr == 0 && !dl) ? 1 : 0;
      lsr_r = (h_rd && h_addr == 5) ? 1 : 0;
      fcr_w = (h_wr && h_addr == 2) ? 1 : 0;
      rbr_w = (m_wr && m_addr == 8'hF0) ? 1 : 0;
      thr_r = (m_rd && m_addr == 8'hF0) ? 1 : 0;
      fcr_r = (m_rd && m_addr == 8'hE9) ? 1 : 0;
      old_thre = thre;
      rx_fire = 0; tx_fire = 0;
      if (rbr_w) begin
        if ((ctl & 1) && rxl != 0) begin rxc = rxl; rxa = 1; end
        else begin rxa = 0; rx_fire = 1; end
      end else if (rxa) begin
        if (rxc == 1) begin rxa = 0; rx_fire = 1; end else rxc--;
      end
      if (thr_r) begin
        if ((ctl & 2) && txl != 0) begin txc = txl; txa = 1; end
        else begin txa = 0; tx_fire = 1; end
      end else if (txa) begin
        if (txc == 1) begin txa = 0; tx_fire = 1; end else txc--;
      end
      if (rbr_w) begin rbr = m_wdata; err = shadow; end
      else if (lsr_r) err = 0;
      if (rx_fire) dr = 1; else if (rbr_r) dr = 0;
      if (thr_w) begin thr = h_wdata; thre = 0; pend = 1; end
      else begin
        if (tx_fire) thre = 1;
        if (thr_r) pend = 0;
      end
      if (thr_w && !old_thre) ovr = 1; else if (fcr_r) ovr = 0;
      if (fcr_w) fwr = 1; else if (fcr_r) fwr = 0;
      if (h_wr) begin
        case (h_addr)
          0: if (dl) dll = h_wdata;
          1: if (dl) dlm = h_wdata; else ier = h_wdata & 8'h0F;
          2: fcr = h_wdata & 8'hCF;
          3: lcr = h_wdata;
          7: scr = h_wdata;
          default: ;
        endcase
      end
      if (m_wr) begin
        case (m_addr)
          8'hF1: shadow = (m_wdata >> 1) & 8'h0F;
          8'hF2: rxl = m_wdata;
          8'hF3: txl = m_wdata;
          8'hF4: ctl = m_wdata & 3;
          8'hF6: mien = m_wdata & 1;
          default: ;
        endcase
      end
    end
  end

  task automatic report(input string what, input int got, input int expv);
    miss++;
    $display("FAIL %s %s got %02h expected %02h at %0t", cur, what, got, expv, $time);
  endtask

  // compare every clock, mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vecs++;
      if (int'(h_rdata) != exp_host()) report("h_rdata", h_rdata, exp_host());
      if (int'(m_rdata) != exp_mpu())  report("m_rdata", m_rdata, exp_mpu());
      if (int'(h_irq) != exp_hirq())   report("h_irq", h_irq, exp_hirq());
      if (int'(m_irq) != (pend & mien)) report("m_irq", m_irq, pend & mien);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      done = 1;
      miss++;
      $display("FAIL watchdog expired in %s", cur);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  task automatic step(input bit hr, input bit hw, input int ha, input int hd,
                      input bit mr, input bit mw, input int ma, input int md);
    @(posedge clk); #2;
    h_rd = hr; h_wr = hw; h_addr = 3'(ha); h_wdata = 8'(hd);
    m_rd = mr; m_wr = mw; m_addr = 8'(ma); m_wdata = 8'(md);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      h_rd = 0; h_wr = 0; m_rd = 0; m_wr = 0;
    end
  endtask

  task automatic hw(input int a, input int d); step(0, 1, a, d, 0, 0, m_addr, 0); idle(1); endtask
  task automatic hr(input int a);              step(1, 0, a, 0, 0, 0, m_addr, 0); idle(1); endtask
  task automatic mw(input int a, input int d); step(0, 0, h_addr, 0, 0, 1, a, d); idle(1); endtask
  task automatic mr(input int a);              step(0, 0, h_addr, 0, 1, 0, a, 0); idle(1); endtask

  initial begin
    idle(3);
    #5 rst_n = 1'b1;
    // R1: reset view
    cur = "R1";
    step(0, 0, 5, 0, 0, 0, 8'hE9, 0); idle(2);
    step(0, 0, 2, 0, 0, 0, 8'hF5, 0); idle(2);
    // R2: receive byte and data-ready
    cur = "R2";
    mw(8'hF0, 8'hA5); hr(5); hr(0); hr(5); mr(8'hF0);
    // R3: shadow errors and collision with status read
    cur = "R3";
    mw(8'hF1, 8'h1E); hr(5); mw(8'hF0, 8'h11); hr(5); hr(5);
    mw(8'hF1, 8'h0A);
    step(1, 0, 5, 0, 0, 1, 8'hF0, 8'h22); idle(1); hr(5);
    step(1, 0, 0, 0, 0, 1, 8'hF0, 8'h23); idle(1); hr(5);
    // R4: host interrupt and identification
    cur = "R4";
    hw(1, 8'hFF); hr(2); hr(0); hr(2); hw(1, 8'h01); hr(2); hw(1, 8'h02); hr(2);
    mw(8'hF0, 8'h44); hr(2); hr(0); hw(1, 8'h00);
    // R5: transmit byte toward the MPU
    cur = "R5";
    mw(8'hF6, 1); hw(0, 8'h3C); mr(8'hF5); mr(8'hF0); mr(8'hF5); hr(5);
    // R6: host write and MPU collect in one cycle
    cur = "R6";
    hw(0, 8'h55);
    step(0, 1, 0, 8'h66, 1, 0, 8'hF0, 0); idle(1); hr(5); mr(8'hF5); mr(8'hF0); hr(5);
    // R9 and R8: overrun and control byte capture
    cur = "R9";
    hw(0, 8'h01); hw(0, 8'h02); mr(8'hE9);
    cur = "R8";
    hw(2, 8'hFF); mr(8'hE9); mr(8'hE9); hw(2, 8'h41);
    step(0, 1, 2, 8'hC9, 1, 0, 8'hE9, 0); idle(1); mr(8'hE9);
    mr(8'hF0);
    // R7: delay counters
    cur = "R7";
    mw(8'hF2, 5); mw(8'hF3, 3); mw(8'hF4, 3); hw(1, 8'h03);
    step(0, 0, 5, 0, 0, 1, 8'hF0, 8'h77); idle(8);
    hr(0);
    step(0, 0, 5, 0, 0, 1, 8'hF0, 8'h78); idle(3);
    step(0, 0, 5, 0, 0, 1, 8'hF0, 8'h79); idle(8);
    hr(0);
    hw(0, 8'h90);
    step(0, 0, 5, 0, 1, 0, 8'hF0, 0); idle(6);
    hw(0, 8'h91);
    step(0, 0, 5, 0, 1, 0, 8'hF0, 0); idle(1);
    step(0, 1, 0, 8'h92, 0, 0, 8'hF0, 0); idle(4);
    mr(8'hF0); idle(4);
    mw(8'hF2, 0); hr(0); mw(8'hF0, 8'h7A); hr(5);
    mw(8'hF4, 0); hw(1, 0);
    // R10: divisor access and line control
    cur = "R10";
    hw(3, 8'h83); hw(0, 8'h0C); hw(1, 8'h00); hr(0); hr(1);
    mr(8'hF7); mr(8'hF8); mr(8'hFA); mr(8'hF0);
    hw(0, 8'h34); hw(1, 8'h12); mr(8'hF7); mr(8'hF8); hr(5);
    hw(3, 8'h03); hr(0); hr(1); mr(8'hFA);
    // R11: scratch and unused addresses
    cur = "R11";
    hw(7, 8'h5A); hr(7); mr(8'hF9);
    hw(4, 8'hFF); hr(4); hw(6, 8'hFF); hr(6); mr(8'h10); mr(8'hF3);
    idle(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule